// File: doc/BRIEF.md
# Display Start Address Latching Unit

This block keeps the scroll and pan state of a raster display controller. A host programs a 20-bit start word address as three byte-wide registers. It also programs a small pixel-pan value and a line pitch in words. The block holds working copies of these values and derives from them, for every display line, the word address at which fetching begins and the number of pixels to skip inside the first fetched word.

Timing generation is outside the block. Three input strobes stand in for it: one marks the start of a frame, one marks the start of a line, and a level input marks the vertical non-display period. The start address is copied into its working register only when a frame begins. The pan value is copied only when a line begins, so host writes take effect on those boundaries and no earlier. To scroll without tearing, the host writes the start address just after vertical blanking ends and writes the pan value during the next blanking period. It watches the blanking status bit to find these points.

Pan masking follows the colour depth. At 15 and 16 bits per pixel one start-address step already moves the image by a single pixel, so the pan value has no effect at those depths. At lower depths only the bits that index a pixel inside one 16-bit word take effect.

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset all host registers read zero, fetch_addr and pix_skip are zero, and the unit waits for a first line start after reset, which loads the working start address.
- R2: Host register 10h holds start address bits 7:0, register 11h holds bits 15:8, and register 12h bits 3:0 hold bits 19:16. Each register reads back what was written.
- R3: Bits 7:4 of register 12h ignore writes and always read zero.
- R4: Register 0Ah reads with bit 7 equal to the vblank input and bits 6:0 zero, and writes to it have no effect.
- R5: fetch_addr changes only in the cycle after a frame_start or line_start strobe. A host write to the start address has no effect on fetch_addr until a later frame.
- R6: A frame_start copies the start address registers into the working start. The first line_start after it sets fetch_addr to that working start, one cycle after the strobe.
- R7: Every later line_start in the frame adds the line pitch register (1Ch, 8 bits, in words) to fetch_addr, modulo 2^20.
- R8: The pan register is copied to pix_skip only at line_start, and the new value appears one cycle after the strobe. pix_skip is otherwise stable.
- R9: pix_depth codes 0,1,2,3 stand for 1,2,4,8 bpp and mask the pan value with Fh, 7h, 3h, 1h. Codes 4 and 5 (15 and 16 bpp), and unused codes 6 and 7, give pix_skip zero.
- R10: The pan register sits at 18h and is 4 bits wide. Bits 7:4 ignore writes and read zero.
- R11: When frame_start and line_start coincide, fetch_addr becomes the start address registers' value one cycle later, and the next line_start advances it by the pitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the addressed register |
| host_addr | input | 8 | Host register byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational read data of the addressed register |
| vblank | input | 1 | High during vertical non-display |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| line_start | input | 1 | One-cycle strobe at the start of each display line |
| pix_depth | input | 3 | Colour depth code (see R9) |
| fetch_addr | output | 20 | Word address of the first fetch of the current line |
| pix_skip | output | 4 | Pixels to skip in the first fetched word |

## Verification
Register writes appear on host_rdata in the cycle after the write edge, and reads are combinational. fetch_addr and pix_skip each move one cycle after the strobe that latches them. The one exception is the frame start: it changes only the hidden working start, which shows up one line strobe later. The bench drives every input on the falling edge and updates its model once per rising edge from the pre-edge state, applying latches before writes. It compares all outputs at the next falling edge, so a write and a strobe in the same cycle are judged by the ordering above.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
    localparam int ADDR_W = 20;
    localparam int BYTE_W = 8;
    localparam int PAN_W  = 4;
    localparam int OFF_W  = 8;
    localparam int DEP_W  = 3;

    localparam logic [BYTE_W-1:0] RA_STAT = 8'h0A;
    localparam logic [BYTE_W-1:0] RA_SA0  = 8'h10;
    localparam logic [BYTE_W-1:0] RA_SA1  = 8'h11;
    localparam logic [BYTE_W-1:0] RA_SA2  = 8'h12;
    localparam logic [BYTE_W-1:0] RA_PAN  = 8'h18;
    localparam logic [BYTE_W-1:0] RA_OFF  = 8'h1C;

    typedef enum logic [DEP_W-1:0] {
        DEP_1  = 3'd0,
        DEP_2  = 3'd1,
        DEP_4  = 3'd2,
        DEP_8  = 3'd3,
        DEP_15 = 3'd4,
        DEP_16 = 3'd5
    } depth_e;
endpackage

// File: rtl/scroll_hostregs.sv
module scroll_hostregs
    import scroll_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PAN_W,
    parameter int OW = OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              vblank,
    output logic [BYTE_W-1:0] rdata,
    output logic [AW-1:0]     start_addr,
    output logic [PW-1:0]     pan_val,
    output logic [OW-1:0]     line_off
);
    localparam int HI_W = AW - 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] sa0;
        logic [BYTE_W-1:0] sa1;
        logic [HI_W-1:0]   sa2;
        logic [PW-1:0]     pan;
        logic [OW-1:0]     off;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                RA_SA0:  r_d.sa0 = wdata;
                RA_SA1:  r_d.sa1 = wdata;
                RA_SA2:  r_d.sa2 = wdata[HI_W-1:0];
                RA_PAN:  r_d.pan = wdata[PW-1:0];
                RA_OFF:  r_d.off = wdata[OW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_STAT: rdata[BYTE_W-1] = vblank;
            RA_SA0:  rdata = r_q.sa0;
            RA_SA1:  rdata = r_q.sa1;
            RA_SA2:  rdata[HI_W-1:0] = r_q.sa2;
            RA_PAN:  rdata[PW-1:0] = r_q.pan;
            RA_OFF:  rdata[OW-1:0] = r_q.off;
            default: rdata = '0;
        endcase
    end

    assign start_addr = {r_q.sa2, r_q.sa1, r_q.sa0};
    assign pan_val    = r_q.pan;
    assign line_off   = r_q.off;

    a_r2_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr && addr == RA_SA0 |=> start_addr[BYTE_W-1:0] == $past(wdata));

    a_r2_mid_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr && addr == RA_SA1 |=> start_addr[2*BYTE_W-1:BYTE_W] == $past(wdata));

    a_r4_status: assert property (@(posedge clk) disable iff (!rst_n)
        addr == RA_STAT |-> rdata == {vblank, {(BYTE_W-1){1'b0}}});

    a_r10_pan_upper: assert property (@(posedge clk) disable iff (!rst_n)
        addr == RA_PAN |-> rdata[BYTE_W-1:PW] == '0);
endmodule

// File: rtl/scroll_frame_latch.sv
module scroll_frame_latch #(
    parameter int AW = 20,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic [AW-1:0] start_in,
    input  logic [OW-1:0] line_off,
    output logic [AW-1:0] fetch_addr
);
    typedef struct packed {
        logic [AW-1:0] work;
        logic [AW-1:0] base;
        logic          first;
    } fl_t;

    fl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.work = start_in;
            if (line_start) begin
                s_d.base  = start_in;
                s_d.first = 1'b0;
            end else begin
                s_d.first = 1'b1;
            end
        end else if (line_start) begin
            if (s_q.first) begin
                s_d.base  = s_q.work;
                s_d.first = 1'b0;
            end else begin
                s_d.base = s_q.base + AW'(line_off);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.work  <= '0;
            s_q.base  <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_addr = s_q.base;

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start && !line_start |=> $stable(fetch_addr));

    a_r6_first_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !line_start ##1 line_start && !frame_start
        |=> fetch_addr == $past(start_in, 2));

    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && !frame_start && !s_q.first
        |=> fetch_addr == AW'($past(fetch_addr) + AW'($past(line_off))));

    a_r11_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && line_start |=> fetch_addr == $past(start_in));
endmodule

// File: rtl/scroll_pan_latch.sv
module scroll_pan_latch #(
    parameter int PW = 4,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [PW-1:0] pan_in,
    input  logic [DW-1:0] depth,
    output logic [PW-1:0] pix_skip
);
    localparam int NARROW = PW;

    typedef struct packed {
        logic [PW-1:0] skip;
    } pl_t;

    pl_t p_d, p_q;
    logic [PW-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < NARROW; i++) begin
            if (int'(depth) == i) mask = PW'((1 << (PW - i)) - 1);
        end
    end

    always_comb begin
        p_d = p_q;
        if (line_start) p_d.skip = pan_in & mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pix_skip = p_q.skip;

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(pix_skip));

    a_r8_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && depth == '0 |=> pix_skip == $past(pan_in));

    a_r9_wide_depth: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && int'(depth) >= NARROW |=> pix_skip == '0);
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
    import scroll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              vblank,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [DEP_W-1:0]  pix_depth,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [PAN_W-1:0]  pix_skip
);
    logic [ADDR_W-1:0] start_reg;
    logic [PAN_W-1:0]  pan_reg;
    logic [OFF_W-1:0]  off_reg;

    scroll_hostregs #(.AW(ADDR_W), .PW(PAN_W), .OW(OFF_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (host_wr),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .vblank     (vblank),
        .rdata      (host_rdata),
        .start_addr (start_reg),
        .pan_val    (pan_reg),
        .line_off   (off_reg)
    );

    scroll_frame_latch #(.AW(ADDR_W), .OW(OFF_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .start_in    (start_reg),
        .line_off    (off_reg),
        .fetch_addr  (fetch_addr)
    );

    scroll_pan_latch #(.PW(PAN_W), .DW(DEP_W)) u_pan (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .pan_in     (pan_reg),
        .depth      (pix_depth),
        .pix_skip   (pix_skip)
    );
endmodule

// File: tb/tb_scroll_addr_unit.sv
module tb_scroll_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        vblank = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic [2:0]  pix_depth = 3'd0;
    logic [19:0] fetch_addr;
    logic [3:0]  pix_skip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [19:0] m_start, m_work, m_base;
    logic [7:0]  m_off;
    logic [3:0]  m_pan, m_skip;
    logic        m_first;

    always #10 clk = ~clk;

    scroll_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .vblank(vblank),
        .frame_start(frame_start), .line_start(line_start),
        .pix_depth(pix_depth), .fetch_addr(fetch_addr), .pix_skip(pix_skip)
    );

    function automatic logic [3:0] pan_mask(input logic [2:0] d);
        case (d)
            3'd0: return 4'hF;
            3'd1: return 4'h7;
            3'd2: return 4'h3;
            3'd3: return 4'h1;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a, input logic vb);
        case (a)
            8'h0A: return {vb, 7'd0};
            8'h10: return m_start[7:0];
            8'h11: return m_start[15:8];
            8'h12: return {4'd0, m_start[19:16]};
            8'h18: return {4'd0, m_pan};
            8'h1C: return m_off;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_start = '0; m_work = '0; m_base = '0; m_off = '0;
        m_pan = '0; m_skip = '0; m_first = 1'b1;
    endtask

    task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input logic fs, input logic ls, input logic vb,
                        input logic [2:0] dep);
        logic [19:0] n_work, n_base;
        logic        n_first;
        host_wr = wr; host_addr = a; host_wdata = d;
        frame_start = fs; line_start = ls; vblank = vb; pix_depth = dep;
        @(posedge clk);
        @(negedge clk);
        n_work = m_work; n_base = m_base; n_first = m_first;
        if (fs) begin
            n_work = m_start;
            if (ls) begin n_base = m_start; n_first = 1'b0; end
            else n_first = 1'b1;
        end else if (ls) begin
            if (m_first) begin n_base = m_work; n_first = 1'b0; end
            else n_base = m_base + 20'(m_off);
        end
        if (ls) m_skip = m_pan & pan_mask(dep);
        m_work = n_work; m_base = n_base; m_first = n_first;
        if (wr) begin
            case (a)
                8'h10: m_start[7:0]   = d;
                8'h11: m_start[15:8]  = d;
                8'h12: m_start[19:16] = d[3:0];
                8'h18: m_pan = d[3:0];
                8'h1C: m_off = d;
                default: ;
            endcase
        end
        host_wr = 1'b0; frame_start = 1'b0; line_start = 1'b0;
        #1;
        chk(fetch_addr == m_base, "R5 R6 R7 R11 fetch_addr", fetch_addr, m_base);
        chk(pix_skip == m_skip, "R8 R9 pix_skip", pix_skip, m_skip);
        chk(host_rdata == model_read(a, vb), "R2 R3 R4 R10 readback",
            host_rdata, model_read(a, vb));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, pix_depth);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0, pix_depth);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ra [7];
        void'($urandom(32'd20250117));
        ra[0] = 8'h10; ra[1] = 8'h11; ra[2] = 8'h12; ra[3] = 8'h18;
        ra[4] = 8'h1C; ra[5] = 8'h0A; ra[6] = 8'h33;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(fetch_addr == 20'h0, "R1 fetch_addr", fetch_addr, 0);
        chk(pix_skip == 4'h0, "R1 pix_skip", pix_skip, 0);
        for (int k = 0; k < 7; k++) begin
            host_addr = ra[k];
            #1;
            chk(host_rdata == 8'h00, "R1 register zero", host_rdata, 0);
        end
        // R1: first line after reset loads working start (zero), no pitch add
        wreg(8'h1C, 8'h20);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        chk(fetch_addr == 20'h0, "R1 first line after reset", fetch_addr, 0);

        // R2 / R3: program start address, upper bits of 12h dropped
        wreg(8'h10, 8'h34);
        wreg(8'h11, 8'h12);
        wreg(8'h12, 8'hFB);
        host_addr = 8'h12; #1;
        chk(host_rdata == 8'h0B, "R3 upper bits of 12h", host_rdata, 8'h0B);
        chk(fetch_addr == 20'h00020 || fetch_addr == 20'h0, "R5 no effect before frame",
            fetch_addr, m_base);

        // R6: frame start, then first line
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 3'd0);
        chk(fetch_addr == 20'h0, "R6 unchanged at frame_start", fetch_addr, 0);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        chk(fetch_addr == 20'hB1234, "R6 first line fetch", fetch_addr, 20'hB1234);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        chk(fetch_addr == 20'hB1254, "R7 pitch step", fetch_addr, 20'hB1254);

        // R5: mid-frame write waits for next frame
        wreg(8'h10, 8'h00);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        chk(fetch_addr == 20'hB1274, "R5 mid-frame write held off", fetch_addr, 20'hB1274);
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 3'd0);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        chk(fetch_addr == 20'hB1200, "R5 write seen next frame", fetch_addr, 20'hB1200);

        // R10 / R8: pan write applied at the next line start
        wreg(8'h18, 8'hFF);
        host_addr = 8'h18; #1;
        chk(host_rdata == 8'h0F, "R10 pan width", host_rdata, 8'h0F);
        idle(3);
        chk(pix_skip == 4'h0, "R8 pan not yet applied", pix_skip, 0);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        chk(pix_skip == 4'hF, "R8 pan at line start", pix_skip, 4'hF);

        // R9: masks by depth
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd1);
        chk(pix_skip == 4'h7, "R9 2bpp mask", pix_skip, 4'h7);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd2);
        chk(pix_skip == 4'h3, "R9 4bpp mask", pix_skip, 4'h3);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd3);
        chk(pix_skip == 4'h1, "R9 8bpp mask", pix_skip, 4'h1);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd4);
        chk(pix_skip == 4'h0, "R9 15bpp ignored", pix_skip, 0);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd5);
        chk(pix_skip == 4'h0, "R9 16bpp ignored", pix_skip, 0);

        // R4: status register
        step(1'b1, 8'h0A, 8'h7F, 1'b0, 1'b0, 1'b1, 3'd0);
        chk(host_rdata == 8'h80, "R4 status in blank", host_rdata, 8'h80);
        vblank = 1'b0; #1;
        chk(host_rdata == 8'h00, "R4 status active", host_rdata, 8'h00);

        // R7 wrap and R11 coincident strobes
        wreg(8'h10, 8'hF0);
        wreg(8'h11, 8'hFF);
        wreg(8'h12, 8'h0F);
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0);
        chk(fetch_addr == 20'hFFFF0, "R11 coincident strobes", fetch_addr, 20'hFFFF0);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        chk(fetch_addr == 20'h00010, "R7 wrap modulo 2^20", fetch_addr, 20'h00010);

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            logic wr, fs, ls, vb;
            logic [7:0] a, d;
            logic [2:0] dep;
            wr  = ($urandom % 4) == 0;
            a   = ra[$urandom % 7];
            d   = 8'($urandom);
            fs  = ($urandom % 150) == 0;
            ls  = ($urandom % 8) == 0;
            vb  = ($urandom % 5) == 0;
            dep = (($urandom % 16) == 0) ? 3'($urandom) : pix_depth;
            step(wr, a, d, fs, ls, vb, dep);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule